// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital control side of a two-channel successive-approximation audio converter. It is modelled behaviourally. After reset it runs a long self-calibration window, and a ready flag stays low for the whole window. Once ready, the block tracks one of two input channels. A falling edge on the sampled hold strobe freezes that channel and starts a fixed-length conversion. The conversion makes one bit decision per step, most significant bit first. The block drives a trial code towards the analog side and receives one comparator bit back for each step.

Results leave the block on a pipelined serial output. The word from a conversion is shifted out during the following conversion, most significant bit first, and each bit advances on a falling serial clock edge. The channel-select input is sampled as each conversion finishes, and that value picks the channel tracked next. Two track outputs and a hold control for an external right-channel sample-and-hold let a system sample both channels at the same instant. The output word can be coded as plain binary or as two's complement.

Top module: `sar_seq`

## Requirements
- R1: While `rst_n_i` is low, `ready_o`, `trk_left_o`, `trk_right_o`, `sdata_o` and `ssh_right_o` are all low, and every internal state is cleared at once, including a conversion or calibration in progress.
- R2: After `rst_n_i` rises, `ready_o` stays low for exactly CAL_CYCLES + 2 master clock edges (two edges of reset release plus the calibration window), then rises and stays high until the next reset.
- R3: While `ready_o` is low, falling edges on `hold_i` start nothing and `sdata_o` stays low.
- R4: `hold_i` is sampled on the master clock. While the block is tracking, the first edge that sees `hold_i` low after it was sampled high starts a conversion. The conversion lasts exactly CONV_CYCLES edges, further `hold_i` edges during it are ignored, and afterwards the block returns to tracking.
- R5: Each conversion makes DATA_W decisions of CONV_CYCLES/DATA_W cycles each, MSB first. `dac_code_o` shows the trial code with the bit under test set (0x8000 on the first step for 16 bits). `cmp_i`=1 keeps the bit and `cmp_i`=0 clears it, so a comparator reporting input >= trial code yields the input code.
- R6: `chan_left_i` (1 = left, 0 = right) is sampled on the last edge of a conversion and selects the channel tracked next. While tracking, exactly one of `trk_left_o`/`trk_right_o` is high, matching that channel. Both are low during conversion and calibration. The first channel after calibration is left.
- R7: The serial register is loaded with the previous result on the edge that starts a conversion, so `sdata_o` shows its MSB from the next cycle. Each falling edge of `sclk_i`, sampled on the master clock, presents the next lower bit.
- R8: With `twos_i`=1 on the last edge of a conversion, the stored result has its MSB (bit DATA_W-1) inverted (two's complement). With `twos_i`=0 it is stored as plain binary. The stored result after reset is all zeros.
- R9: `ssh_right_o` goes high on the start of a left-channel conversion and low on the start of a right-channel conversion, and holds its level in between.
- R10: A reset during a conversion aborts it, clears the stored result, and starts a fresh calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| hold_i | input | 1 | Hold strobe; a sampled falling edge starts a conversion |
| chan_left_i | input | 1 | Next-channel select, 1 = left, 0 = right |
| sclk_i | input | 1 | Serial clock, sampled on the master clock |
| twos_i | input | 1 | Output coding, 1 = two's complement, 0 = binary |
| cmp_i | input | 1 | Comparator decision for the current trial code |
| dac_code_o | output | DATA_W | Trial code for the capacitor array |
| ready_o | output | 1 | High once calibration has finished |
| sdata_o | output | 1 | Serial result data, MSB first |
| trk_left_o | output | 1 | Left channel is being tracked |
| trk_right_o | output | 1 | Right channel is being tracked |
| ssh_right_o | output | 1 | Hold control for an external right-channel sample-and-hold |

## Verification
A corrupted decision register would show within one conversion. The serial word sent during the next conversion would then differ from the analog code the bench's comparator model was given, and the bench checks this for edge codes and random codes in both codings. A wrong step or calibration count would move the exact cycle on which the track outputs or `ready_o` change, and the bench checks the cycle before and the cycle of each such change. A wrong channel or hold-control state would show on the track outputs one cycle after a conversion ends, or on `ssh_right_o` one cycle after the next conversion starts. The bench moves `chan_left_i` mid-conversion, so a block that samples it at the start would show the wrong channel.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_CAL   = 2'd0,
    ST_TRACK = 2'd1,
    ST_CONV  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_seq_pkg::*;
#(
  parameter int CAL_CYCLES  = 34584480,
  parameter int CONV_CYCLES = 192,
  parameter int STEPS       = 16
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic hold_i,
  input  logic chan_left_i,
  output logic start_o,
  output logic step_o,
  output logic last_o,
  output logic ready_o,
  output logic trk_left_o,
  output logic trk_right_o,
  output logic ssh_o
);
  localparam int STEP_LEN = CONV_CYCLES / STEPS;
  localparam int CNT_W    = $clog2(CAL_CYCLES + 1);
  localparam int SC_W     = (STEP_LEN > 1) ? $clog2(STEP_LEN) : 1;
  localparam int BIT_W    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_CYCLES - 1);
  localparam logic [SC_W-1:0]  STEP_LAST = SC_W'(STEP_LEN - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(STEPS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cal_cnt_q, cal_cnt_d;
  logic [SC_W-1:0]  step_cnt_q, step_cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             chan_q, chan_d;
  logic             ssh_q, ssh_d;
  logic             hold_q;
  logic             hold_fall;

  assign hold_fall = hold_q & ~hold_i;
  assign start_o   = (state_q == ST_TRACK) & hold_fall;
  assign step_o    = (state_q == ST_CONV) & (step_cnt_q == STEP_LAST);
  assign last_o    = step_o & (bit_q == BIT_LAST);

  always_comb begin
    state_d    = state_q;
    cal_cnt_d  = cal_cnt_q;
    step_cnt_d = step_cnt_q;
    bit_d      = bit_q;
    chan_d     = chan_q;
    ssh_d      = ssh_q;
    case (state_q)
      ST_CAL: begin
        if (cal_cnt_q == CAL_LAST) begin
          state_d   = ST_TRACK;
          cal_cnt_d = '0;
        end else begin
          cal_cnt_d = cal_cnt_q + 1'b1;
        end
      end
      ST_TRACK: begin
        if (start_o) begin
          state_d    = ST_CONV;
          step_cnt_d = '0;
          bit_d      = '0;
          ssh_d      = chan_q;
        end
      end
      ST_CONV: begin
        if (step_o) begin
          step_cnt_d = '0;
          bit_d      = bit_q + 1'b1;
        end else begin
          step_cnt_d = step_cnt_q + 1'b1;
        end
        if (last_o) begin
          state_d = ST_TRACK;
          chan_d  = chan_left_i;
        end
      end
      default: state_d = ST_CAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_CAL;
      cal_cnt_q  <= '0;
      step_cnt_q <= '0;
      bit_q      <= '0;
      chan_q     <= 1'b1;
      ssh_q      <= 1'b0;
      hold_q     <= 1'b1;
    end else begin
      state_q    <= state_d;
      cal_cnt_q  <= cal_cnt_d;
      step_cnt_q <= step_cnt_d;
      bit_q      <= bit_d;
      chan_q     <= chan_d;
      ssh_q      <= ssh_d;
      hold_q     <= hold_i;
    end
  end

  assign ready_o     = (state_q != ST_CAL);
  assign trk_left_o  = (state_q == ST_TRACK) & chan_q;
  assign trk_right_o = (state_q == ST_TRACK) & ~chan_q;
  assign ssh_o       = ssh_q;

  // R4: a running conversion is not cut short by hold activity
  assert_conv_len_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_CONV && !last_o) |=> (state_q == ST_CONV));
  // R4: the final decision returns the block to tracking
  assert_conv_end_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    last_o |=> (state_q == ST_TRACK));
  // R6: channel tracked next follows the select level at the final edge
  assert_chan_pick_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    last_o |=> (trk_left_o == $past(chan_left_i)));
  // R9: right hold engaged when a left conversion starts
  assert_ssh_set_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_o && trk_left_o) |=> ssh_o);
  // R9: right hold released when a right conversion starts
  assert_ssh_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_o && trk_right_o) |=> !ssh_o);
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] final_o
);
  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sar_q, sar_d;
  logic [DATA_W-1:0] mask_q, mask_d;
  logic [DATA_W-1:0] kept;

  assign kept = cmp_i ? sar_q : (sar_q & ~mask_q);

  always_comb begin
    sar_d  = sar_q;
    mask_d = mask_q;
    if (start_i) begin
      sar_d  = TOP_BIT;
      mask_d = TOP_BIT;
    end else if (step_i) begin
      mask_d = mask_q >> 1;
      sar_d  = kept | (mask_q >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sar_q  <= '0;
      mask_q <= '0;
    end else begin
      sar_q  <= sar_d;
      mask_q <= mask_d;
    end
  end

  assign trial_o = sar_q;
  assign final_o = kept;

  // R5: at most one bit is under test at any time
  assert_mask_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(mask_q));
  // R5: the first trial code sets only the top bit
  assert_first_trial_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i |=> (trial_o == TOP_BIT));
endmodule

// File: rtl/sar_shift.sv
module sar_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              res_we_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              twos_i,
  input  logic              sclk_i,
  output logic              sdata_o
);
  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] res_q, res_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sclk_q;
  logic              sclk_fall;

  assign sclk_fall = sclk_q & ~sclk_i;

  always_comb begin
    res_d = res_q;
    if (res_we_i) res_d = twos_i ? (res_i ^ TOP_BIT) : res_i;
  end

  always_comb begin
    sh_d = sh_q;
    if (load_i)         sh_d = res_q;
    else if (sclk_fall) sh_d = {sh_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      sh_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      sh_q   <= sh_d;
      sclk_q <= sclk_i;
    end
  end

  assign sdata_o = sh_q[DATA_W-1];

  // R7: the stored word's top bit is on the line right after a load
  assert_load_msb_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    load_i |=> (sdata_o == $past(res_q[DATA_W-1])));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 192,
  parameter int CAL_CYCLES  = 34584480
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              hold_i,
  input  logic              chan_left_i,
  input  logic              sclk_i,
  input  logic              twos_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              ready_o,
  output logic              sdata_o,
  output logic              trk_left_o,
  output logic              trk_right_o,
  output logic              ssh_right_o
);
  logic              rst_n;
  logic              start, step, last;
  logic [DATA_W-1:0] final_code;

  sar_rst_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n)
  );

  sar_ctrl #(
    .CAL_CYCLES  (CAL_CYCLES),
    .CONV_CYCLES (CONV_CYCLES),
    .STEPS       (DATA_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .hold_i      (hold_i),
    .chan_left_i (chan_left_i),
    .start_o     (start),
    .step_o      (step),
    .last_o      (last),
    .ready_o     (ready_o),
    .trk_left_o  (trk_left_o),
    .trk_right_o (trk_right_o),
    .ssh_o       (ssh_right_o)
  );

  sar_reg #(.DATA_W(DATA_W)) u_sar (
    .clk_i   (clk_i),
    .rst_n   (rst_n),
    .start_i (start),
    .step_i  (step),
    .cmp_i   (cmp_i),
    .trial_o (dac_code_o),
    .final_o (final_code)
  );

  sar_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .load_i   (start),
    .res_we_i (last),
    .res_i    (final_code),
    .twos_i   (twos_i),
    .sclk_i   (sclk_i),
    .sdata_o  (sdata_o)
  );

  // R3: nothing leaves the serial pin before calibration is done
  assert_quiet_cal_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ready_o |-> !sdata_o);
  // R6: never both track outputs at once
  assert_trk_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({trk_left_o, trk_right_o}));
  // R2: ready only drops through reset
  assert_ready_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    ready_o |=> ready_o);
endmodule

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
  localparam int W    = 16;
  localparam int CAL  = 40;
  localparam int CONV = 192;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, hold, chan_left, sclk, twos;
  logic         cmp;
  logic [W-1:0] dac, analog;
  logic         ready, sdata, trk_l, trk_r, ssh;

  assign cmp = (analog >= dac);

  sar_seq #(.DATA_W(W), .CONV_CYCLES(CONV), .CAL_CYCLES(CAL)) u0 (
    .clk_i(clk), .rst_n_i(rst_n), .hold_i(hold), .chan_left_i(chan_left),
    .sclk_i(sclk), .twos_i(twos), .cmp_i(cmp), .dac_code_o(dac),
    .ready_o(ready), .sdata_o(sdata), .trk_left_o(trk_l),
    .trk_right_o(trk_r), .ssh_right_o(ssh)
  );

  int           checks = 0;
  int           errors = 0;
  logic [W-1:0] prev;
  logic         exp_left;
  int           t;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
    t += n;
  endtask

  function automatic logic [W-1:0] coded(input logic [W-1:0] v, input logic tc);
    return tc ? (v ^ {1'b1, {(W-1){1'b0}}}) : v;
  endfunction

  task automatic do_reset();
    logic bad;
    bad = 1'b0;
    rst_n = 1'b0; hold = 1'b1; sclk = 1'b0;
    adv(3);
    chk(!ready && !trk_l && !trk_r && !sdata && !ssh, "R1",
        {ready, trk_l, trk_r, sdata, ssh}, 0);
    rst_n = 1'b1;
    for (int i = 1; i <= CAL + 1; i++) begin
      if (i < CAL - 3 && (i % 4) == 2) hold = ~hold;
      if (i >= CAL - 3) hold = 1'b1;
      adv(1);
      if (sdata || trk_l || trk_r) bad = 1'b1;
    end
    chk(!bad, "R3", bad, 0);
    chk(ready == 1'b0, "R2", ready, 0);
    adv(1);
    chk(ready == 1'b1, "R2", ready, 1);
    chk(trk_l && !trk_r, "R6", {trk_l, trk_r}, 2);
    prev = '0;
    exp_left = 1'b1;
  endtask

  task automatic run_conv(input logic [W-1:0] val, input logic next_left,
                          input logic tc, input logic glitch);
    logic [W-1:0] got;
    logic         cur_left;
    cur_left = exp_left;
    analog = val; twos = tc;
    hold = 1'b0; chan_left = ~next_left;
    t = 0;
    adv(1);
    chk(!trk_l && !trk_r, "R6", {trk_l, trk_r}, 0);
    chk(ssh == cur_left, "R9", ssh, cur_left);
    chk(dac == {1'b1, {(W-1){1'b0}}}, "R5", dac, 16'h8000);
    hold = 1'b1;
    got[W-1] = sdata;
    for (int b = W - 2; b >= 0; b--) begin
      sclk = 1'b1; adv(1);
      sclk = 1'b0; adv(1);
      got[b] = sdata;
    end
    chk(got == prev, "R7 R8", got, prev);
    adv(100 - t);
    if (glitch) hold = 1'b0;
    adv(2);
    hold = 1'b1;
    adv(150 - t);
    chan_left = next_left;
    adv(CONV - t);
    chk(!trk_l && !trk_r, "R4", {trk_l, trk_r}, 0);
    adv(1);
    chk(trk_l == next_left && trk_r == !next_left, "R4 R6",
        {trk_l, trk_r}, {next_left, !next_left});
    prev = coded(val, tc);
    exp_left = next_left;
    adv(5);
  endtask

  initial begin
    void'($urandom(32'd7351));
    hold = 1'b1; chan_left = 1'b1; sclk = 1'b0; twos = 1'b0;
    analog = '0; rst_n = 1'b0;
    do_reset();

    // R5 R8 directed corner codes, both codings
    run_conv(16'h0000, 1'b0, 1'b0, 1'b0);
    run_conv(16'hFFFF, 1'b1, 1'b0, 1'b1);
    run_conv(16'h8000, 1'b1, 1'b1, 1'b0);
    run_conv(16'h7FFF, 1'b0, 1'b1, 1'b1);
    run_conv(16'h0001, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++)
      run_conv(16'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));

    // R10 reset in the middle of a conversion
    analog = 16'h1234; hold = 1'b0;
    adv(1);
    hold = 1'b1;
    adv(49);
    rst_n = 1'b0;
    adv(1);
    chk(!ready && !trk_l && !trk_r && !sdata && !ssh, "R10 R1",
        {ready, trk_l, trk_r, sdata, ssh}, 0);
    do_reset();
    run_conv(16'hA5A5, 1'b1, 1'b1, 1'b0);
    run_conv(16'h5A5A, 1'b0, 1'b0, 1'b0);
    run_conv(16'h0F0F, 1'b1, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule